// File: doc/BRIEF.md
# Masked Interrupt Cause Controller

This block gathers six per-channel cause strobes (one completion cause and five fault causes) into a sticky cause register. A cause bit sets on the rising edge of its strobe. It stays set until software writes a one to its position in a clear register. An enable register masks the causes. The masked result drives one of two delivery schemes: a level interrupt line, or a train of single-cycle message pulses. In message mode each pulse carries the one-hot code of a single cause. A separate fault output is high while any enabled fault cause is set, whichever delivery scheme is selected.

Software reaches the registers over a simple synchronous bus. Writes take effect on the clock edge where the write strobe is high. Read data is registered and appears one cycle after the read strobe. A typical service routine reads the cause register, writes the bits it has handled back to the clear register, and then reads again. Causes that arrived while it was working are still latched and show up on that second read.

The message sequencer is a three-state machine. `SEQ_IDLE` moves to `SEQ_SEND` when there is a pending cause and message mode is selected; on that move it takes the lowest-numbered pending cause. `SEQ_SEND` always moves to `SEQ_GAP`, and `SEQ_GAP` always returns to `SEQ_IDLE`.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset the cause register and the enable register read 0, the mode field reads 1 (level delivery), and `irq_level`, `err_active` and `msg_valid` are low.
- R2: Strobe inputs 0..5 map to cause bits 0, 1, 9, 10, 11 and 14. Only a rising edge of a strobe sets its bit, so a strobe held high does not set the bit again after it is cleared. All other cause-register bits always read 0.
- R3: Writing to offset 0x108 clears each cause bit whose data bit is 1 and leaves every bit whose data bit is 0. Reads of 0x108 return 0.
- R4: When a strobe edge and a clear of the same bit fall in the same cycle, the bit ends up set. Other bits in that same clear write are still cleared.
- R5: The enable register at offset 0x110 holds only bits 0, 1, 9, 10, 11 and 14 and reads back with every other bit 0. The cause register reads at offset 0x100.
- R6: The mode field at offset 0x004 is 4 bits wide, held in data bits 3:0, and reads back with the upper bits 0. The value 1 selects level delivery. Every other value, including 0, selects message delivery.
- R7: In level mode, `irq_level` is high exactly when (cause AND enable) is non-zero.
- R8: `err_active` is high exactly when (cause AND enable) has any of bits 1, 9, 10, 11 or 14 set, in either delivery mode. Bit 0 is the only non-fault cause.
- R9: In message mode `irq_level` stays low. A cause bit that goes from 0 to 1 while its enable bit is set produces exactly one `msg_valid` pulse, one cycle long, with `msg_cause` holding that bit alone. When several such bits arrive together they are sent lowest-numbered first, with idle cycles between pulses. A strobe on a bit that is already set produces no pulse.
- R10: Cause bits stay latched until cleared, so later causes add to earlier ones. Changing the enable register never alters the cause register.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | NUM_SRC (6) | Cause strobes, index 0..5 mapped to bits 0, 1, 9, 10, 11, 14 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Registered read data |
| irq_level | output | 1 | Level interrupt, level mode only |
| msg_valid | output | 1 | One-cycle message pulse |
| msg_cause | output | CAUSE_W (16) | One-hot cause sent with the pulse |
| err_active | output | 1 | Some enabled fault cause is set |

## Verification
The bench builds the block with its defaults: a 12-bit offset, a 16-bit data path and six strobes. With six cause bits there are only 64 possible enable patterns and 64 possible clear patterns. The bench sweeps every enable pattern in level mode and again in message mode, checking the level line, the fault output, and the count and order of pulses, and it applies every clear pattern to a full cause register. Directed cases add the held strobe, a set and a clear in the same cycle, non-zero mode values other than 1, and unmapped reads.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int CAUSE_W = 16;
    localparam int NUM_SRC = 6;

    // live cause positions; bit 0 is the only non-fault cause
    localparam logic [CAUSE_W-1:0] CAUSE_MASK = 16'h4E03;
    localparam logic [CAUSE_W-1:0] FAULT_MASK = 16'h4E02;

    localparam logic [11:0] OFF_MODE  = 12'h004;
    localparam logic [11:0] OFF_CAUSE = 12'h100;
    localparam logic [11:0] OFF_CLEAR = 12'h108;
    localparam logic [11:0] OFF_EN    = 12'h110;

    localparam logic [3:0] MODE_LEVEL = 4'd1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SEND = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_t;

    // strobe index -> cause bit position
    function automatic int pos_of(input int k);
        case (k)
            0:       pos_of = 0;
            1:       pos_of = 1;
            2:       pos_of = 9;
            3:       pos_of = 10;
            4:       pos_of = 11;
            default: pos_of = 14;
        endcase
    endfunction
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [CAUSE_W-1:0] clr_in,
    output logic [CAUSE_W-1:0] rise_o,
    output logic [CAUSE_W-1:0] stat_o
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_live
        localparam int P = pos_of(k);
        logic src_q;
        logic stat_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q  <= 1'b0;
                stat_q <= 1'b0;
            end else begin
                src_q <= src_in[k];
                if (src_in[k] && !src_q) begin
                    stat_q <= 1'b1;          // set beats clear
                end else if (clr_in[P]) begin
                    stat_q <= 1'b0;
                end
            end
        end

        assign rise_o[P] = src_in[k] & ~src_q;
        assign stat_o[P] = stat_q;
    end

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_dead
        if (!CAUSE_MASK[i]) begin : g_tie
            assign rise_o[i] = 1'b0;
            assign stat_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CAUSE_W-1:0] stat_i,
    output logic [DATA_W-1:0]  rdata,
    output logic [CAUSE_W-1:0] en_o,
    output logic [3:0]         mode_o,
    output logic [CAUSE_W-1:0] clr_o
);
    logic hit_mode, hit_cause, hit_clear, hit_en;
    logic [CAUSE_W-1:0] en_q;
    logic [3:0]         mode_q;
    logic [DATA_W-1:0]  rdata_q, rdata_d;

    assign hit_mode  = (addr == ADDR_W'(OFF_MODE));
    assign hit_cause = (addr == ADDR_W'(OFF_CAUSE));
    assign hit_clear = (addr == ADDR_W'(OFF_CLEAR));
    assign hit_en    = (addr == ADDR_W'(OFF_EN));

    assign clr_o = (wr && hit_clear) ? (wdata[CAUSE_W-1:0] & CAUSE_MASK) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= MODE_LEVEL;
        end else if (wr) begin
            if (hit_en)   en_q   <= wdata[CAUSE_W-1:0] & CAUSE_MASK;
            if (hit_mode) mode_q <= wdata[3:0];
        end
    end

    always_comb begin
        rdata_d = '0;
        if (hit_cause) begin
            rdata_d[CAUSE_W-1:0] = stat_i;
        end else if (hit_en) begin
            rdata_d[CAUSE_W-1:0] = en_q;
        end else if (hit_mode) begin
            rdata_d[3:0] = mode_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata  = rdata_q;
    assign en_o   = en_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/irq_msg_seq.sv
module irq_msg_seq
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_en,
    input  logic [CAUSE_W-1:0] new_vec,
    output logic               msg_valid,
    output logic [CAUSE_W-1:0] msg_cause
);
    seq_state_t         st_q, st_d;
    logic [CAUSE_W-1:0] pend_q, pend_d;
    logic [CAUSE_W-1:0] sel_q, sel_d;
    logic [CAUSE_W-1:0] lowest, take;

    assign lowest = pend_q & (~pend_q + 1'b1);

    always_comb begin
        st_d  = st_q;
        sel_d = sel_q;
        take  = '0;
        unique case (st_q)
            SEQ_IDLE: begin
                if (msg_en && (pend_q != '0)) begin
                    take  = lowest;
                    sel_d = lowest;
                    st_d  = SEQ_SEND;
                end
            end
            SEQ_SEND: st_d = SEQ_GAP;
            SEQ_GAP:  st_d = SEQ_IDLE;
            default:  st_d = SEQ_IDLE;
        endcase
        pend_d = msg_en ? ((pend_q & ~take) | new_vec) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            sel_q  <= '0;
            pend_q <= '0;
        end else begin
            st_q   <= st_d;
            sel_q  <= sel_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        msg_valid = (st_q == SEQ_SEND);
        msg_cause = msg_valid ? sel_q : '0;
    end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_level,
    output logic               msg_valid,
    output logic [CAUSE_W-1:0] msg_cause,
    output logic               err_active
);
    logic [CAUSE_W-1:0] stat_q, rise_vec, clr_vec, en_q, eff;
    logic [3:0]         mode_q;
    logic               level_mode;

    irq_src_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_pulse),
        .clr_in (clr_vec),
        .rise_o (rise_vec),
        .stat_o (stat_q)
    );

    irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .stat_i (stat_q),
        .rdata  (bus_rdata),
        .en_o   (en_q),
        .mode_o (mode_q),
        .clr_o  (clr_vec)
    );

    assign level_mode = (mode_q == MODE_LEVEL);
    assign eff        = stat_q & en_q;

    irq_msg_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_en    (!level_mode),
        .new_vec   (rise_vec & ~stat_q & en_q),
        .msg_valid (msg_valid),
        .msg_cause (msg_cause)
    );

    assign irq_level  = level_mode && (eff != '0);
    assign err_active = ((eff & FAULT_MASK) != '0);
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [CAUSE_W-1:0] stat_q,
    input logic [CAUSE_W-1:0] en_q,
    input logic [CAUSE_W-1:0] rise_vec,
    input logic               irq_level,
    input logic               msg_valid,
    input logic [CAUSE_W-1:0] msg_cause
);
    assert_dead_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & ~CAUSE_MASK) == '0);

    assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_vec != '0) |=> ((stat_q & $past(rise_vec)) == $past(rise_vec)));

    assert_irq_needs_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level |-> ((stat_q & en_q) != '0));

    assert_no_mixed_delivery_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_level && msg_valid));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    assert_pulse_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($countones(msg_cause) == 1 && (msg_cause & ~CAUSE_MASK) == '0));
endmodule

bind irq_cause_ctrl irq_cause_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .rise_vec  (rise_vec),
    .irq_level (irq_level),
    .msg_valid (msg_valid),
    .msg_cause (msg_cause)
);

// File: tb/sim_irq_cause_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cause_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src_pulse = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_level, msg_valid, err_active;
    logic [15:0] msg_cause;

    int total = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] mlog [64];
    int mcnt = 0;

    always #4 clk = ~clk;

    irq_cause_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .msg_valid(msg_valid),
        .msg_cause(msg_cause), .err_active(err_active)
    );

    always @(negedge clk) begin
        if (msg_valid) begin
            mlog[mcnt % 64] = msg_cause;
            mcnt = mcnt + 1;
        end
    end

    function automatic logic [15:0] spread(input int e);
        logic [15:0] v = '0;
        if (e & 1)  v[0]  = 1'b1;
        if (e & 2)  v[1]  = 1'b1;
        if (e & 4)  v[9]  = 1'b1;
        if (e & 8)  v[10] = 1'b1;
        if (e & 16) v[11] = 1'b1;
        if (e & 32) v[14] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic strobe(input logic [5:0] m);
        @(negedge clk);
        src_pulse = m;
        @(negedge clk);
        src_pulse = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [15:0] rd;
        int base, j, pc;
        logic [15:0] ex;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        bus_read(12'h100, rd); chk("R1 cause", rd, 16'h0000);
        bus_read(12'h110, rd); chk("R1 enable", rd, 16'h0000);
        bus_read(12'h004, rd); chk("R1 mode", rd, 16'h0001);
        chk("R1 outputs", {13'b0, irq_level, err_active, msg_valid}, 16'h0);

        // R2 / R7 / R8 single causes, level mode
        bus_write(12'h110, 16'hFFFF);
        bus_read(12'h110, rd); chk("R5 enable readback", rd, 16'h4E03);
        for (int k = 0; k < 6; k++) begin
            strobe(6'(1 << k));
            bus_read(12'h100, rd); chk("R2 map", rd, spread(1 << k));
            chk("R7 level", {15'b0, irq_level}, 16'h1);
            chk("R8 fault", {15'b0, err_active}, {15'b0, (k != 0)});
            bus_write(12'h108, spread(1 << k));
            bus_read(12'h100, rd); chk("R3 cleared", rd, 16'h0);
            chk("R7 level off", {15'b0, irq_level}, 16'h0);
        end

        // R2 held strobe does not reset after clear
        @(negedge clk); src_pulse = 6'h01;
        idle(2);
        bus_write(12'h108, 16'h0001);
        idle(2);
        bus_read(12'h100, rd); chk("R2 held strobe", rd, 16'h0000);
        @(negedge clk); src_pulse = '0;

        // R10 latching
        strobe(6'h01);
        strobe(6'h04);
        bus_read(12'h100, rd); chk("R10 accumulate", rd, 16'h0201);
        bus_write(12'h108, 16'h0001);
        bus_read(12'h100, rd); chk("R10 partial clear", rd, 16'h0200);
        chk("R7 still high", {15'b0, irq_level}, 16'h1);
        bus_write(12'h110, 16'h0000);
        bus_read(12'h100, rd); chk("R10 enable no effect", rd, 16'h0200);
        chk("R7 masked", {15'b0, irq_level}, 16'h0);
        bus_write(12'h108, 16'hFFFF);

        // R4 set wins over clear
        strobe(6'h01);
        @(negedge clk);
        src_pulse = 6'h04; bus_wr = 1'b1; bus_addr = 12'h108; bus_wdata = 16'h0201;
        @(negedge clk);
        src_pulse = '0; bus_wr = 1'b0;
        bus_read(12'h100, rd); chk("R4 set wins", rd, 16'h0200);
        bus_write(12'h108, 16'hFFFF);

        // R5/R7/R8 exhaustive enable sweep, level mode
        strobe(6'h3F);
        for (int e = 0; e < 64; e++) begin
            bus_write(12'h110, spread(e));
            bus_read(12'h110, rd); chk("R5 sweep", rd, spread(e));
            chk("R7 sweep", {15'b0, irq_level}, {15'b0, (e != 0)});
            chk("R8 sweep", {15'b0, err_active}, {15'b0, ((spread(e) & 16'h4E02) != 0)});
        end

        // R3 exhaustive clear sweep
        for (int c = 0; c < 64; c++) begin
            bus_write(12'h108, 16'hFFFF);
            strobe(6'h3F);
            bus_write(12'h108, spread(c));
            bus_read(12'h100, rd); chk("R3 sweep", rd, 16'h4E03 & ~spread(c));
        end
        bus_read(12'h108, rd); chk("R3 clear reads 0", rd, 16'h0);

        // R6 mode field
        bus_write(12'h004, 16'hFFF1);
        bus_read(12'h004, rd); chk("R6 nibble", rd, 16'h0001);
        bus_write(12'h004, 16'h0005);
        bus_read(12'h004, rd); chk("R6 value 5", rd, 16'h0005);
        bus_write(12'h110, 16'hFFFF);
        bus_write(12'h108, 16'hFFFF);
        base = mcnt;
        strobe(6'h01);
        idle(10);
        chk("R6 mode 5 pulses", 16'(mcnt - base), 16'd1);
        chk("R9 level low", {15'b0, irq_level}, 16'h0);

        // R9 exhaustive message sweep, mode 0
        bus_write(12'h004, 16'h0000);
        for (int e = 0; e < 64; e++) begin
            bus_write(12'h108, 16'hFFFF);
            bus_write(12'h110, spread(e));
            idle(4);
            base = mcnt;
            strobe(6'h3F);
            idle(30);
            pc = 0;
            for (int k = 0; k < 6; k++) if (e & (1 << k)) pc++;
            chk("R9 count", 16'(mcnt - base), 16'(pc));
            j = 0;
            for (int k = 0; k < 6; k++) begin
                if (e & (1 << k)) begin
                    ex = spread(1 << k);
                    if (j < pc && (mcnt - base) == pc)
                        chk("R9 order", mlog[(base + j) % 64], ex);
                    j++;
                end
            end
            chk("R9 no level", {15'b0, irq_level}, 16'h0);
            chk("R8 msg mode", {15'b0, err_active}, {15'b0, ((spread(e) & 16'h4E02) != 0)});
        end
        // R9 already-set causes make no pulse
        base = mcnt;
        strobe(6'h3F);
        idle(20);
        chk("R9 no repeat", 16'(mcnt - base), 16'd0);

        // R11 unmapped read
        bus_read(12'h200, rd); chk("R11 unmapped", rd, 16'h0);
        bus_read(12'h004, rd); chk("R11 latency", rd, 16'h0000);

        summary();
    end
endmodule